// File: doc/BRIEF.md
# Compare Waveform Timer Channel

A single timer channel that counts every clock cycle while enabled and shapes two output levels, A and B, from its own compare matches, from an edge on a selectable external line, and from a software trigger. Three compare values (A, B, C) are held on input ports. Each output gets its own 2-bit action for each kind of event that can reach it. The counter can run up or up-down, and compare C can optionally act as the wrap or turn-around point.

A trigger, which is either the software trigger or an external edge with the trigger enable set, restarts the count from zero. A compare C match can freeze the counter until the next trigger, or switch the clock off until the next start command. A small status word holds compare and overflow flags that clear when read, plus live copies of both outputs.

Top module: `wave_timer_channel`

## Requirements
- R1: After reset, both outputs are low, the count is 0, every status bit is 0 and the counter clock is off.
- R2: The count moves by one per cycle only while the clock is on and the counter is not frozen. `cmd_start` turns the clock on. `cmd_halt` turns it off and wins when both are raised together.
- R3: `wave_mode` 0 counts up and wraps from all-ones to 0. In any mode, a running cycle with the count at all-ones sets status bit 0.
- R4: `wave_mode` 2 counts up. In a running cycle where the count equals compare C, the next count is 0.
- R5: `wave_mode` 1 counts up to all-ones and `wave_mode` 3 counts up to compare C. At that limit both modes turn and count down to 0, then turn up again. If the limit is 0, the count stays at 0.
- R6: A trigger makes the next count 0 with the direction up, and it unfreezes the counter. The trigger is `cmd_swtrig`, or an external event while `evt_is_trig` is 1. It does not change whether the clock is on.
- R7: Action codes are 0 none, 1 set, 2 clear and 3 toggle. The chosen action shows on the output one cycle after the event. A compare event occurs only in a running cycle where the count equals that compare value.
- R8: When several events reach one output in the same cycle, only the highest-ranked event with a non-zero action counts. The ranking is software trigger, then external event, then compare C, then the output's own compare (A for output A, B for output B).
- R9: `evt_src` selects the event line: 0 is `in_b`, and 1, 2, 3 are `xclk[0]`, `xclk[1]`, `xclk[2]`. `evt_edge` selects 0 none, 1 rising, 2 falling, 3 both edges. Edges are seen between consecutive clock samples, and an event drives the output actions whatever `evt_is_trig` holds.
- R10: If `stop_at_c` is set, a compare C match freezes the count until a trigger. If `halt_at_c` is set, a compare C match turns the clock off until `cmd_start`.
- R11: Status bits 2, 3 and 4 flag compare A, B and C matches, and bit 0 flags overflow. The flags are sticky and clear in the cycle after `stat_rd`, except for events that occur in that same read cycle. Bits 17 and 18 follow outputs A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Turn the counter clock on |
| cmd_halt | input | 1 | Turn the counter clock off |
| cmd_swtrig | input | 1 | Software trigger |
| wave_mode | input | 2 | Counting mode |
| cmp_a | input | CNT_W | Compare A value |
| cmp_b | input | CNT_W | Compare B value |
| cmp_c | input | CNT_W | Compare C value |
| stop_at_c | input | 1 | Freeze the counter on a compare C match |
| halt_at_c | input | 1 | Turn the clock off on a compare C match |
| evt_edge | input | 2 | External event edge select |
| evt_src | input | 2 | External event line select |
| evt_is_trig | input | 1 | External event also acts as a trigger |
| in_b | input | 1 | Event line 0 |
| xclk | input | 3 | Event lines 1 to 3 |
| a_act_cmpa | input | 2 | Output A action on compare A |
| a_act_cmpc | input | 2 | Output A action on compare C |
| a_act_evt | input | 2 | Output A action on external event |
| a_act_sw | input | 2 | Output A action on software trigger |
| b_act_cmpb | input | 2 | Output B action on compare B |
| b_act_cmpc | input | 2 | Output B action on compare C |
| b_act_evt | input | 2 | Output B action on external event |
| b_act_sw | input | 2 | Output B action on software trigger |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CNT_W | Counter value |
| status | output | 19 | Flags and output copies |

## Verification
Every result is registered, so the count, both outputs and the status word reflect a cycle's inputs exactly one clock edge later. Examples are a compare match, an event, a trigger and a read clear. A frozen or halted counter first holds its value at the edge after the one that registered the stop. The driver places the inputs for a cycle half a period before the edge and queues the expected post-edge values. The monitor removes one entry 2 ns after each edge and compares it, so each expectation is checked in the cycle where it becomes due.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        WAVE_UP        = 2'd0,
        WAVE_UPDN      = 2'd1,
        WAVE_UP_CRST   = 2'd2,
        WAVE_UPDN_CTOP = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_e;

    localparam int STAT_W    = 19;
    localparam int ST_OVF    = 0;
    localparam int ST_CMPA   = 2;
    localparam int ST_CMPB   = 3;
    localparam int ST_CMPC   = 4;
    localparam int ST_MIRR_A = 17;
    localparam int ST_MIRR_B = 18;

endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] top_c,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    import wt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             up;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = (wave_e'(mode) == WAVE_UPDN_CTOP) ? top_c : CNT_MAX;
        if (restart) begin
            st_d.val = '0;
            st_d.up  = 1'b1;
        end else if (run) begin
            case (wave_e'(mode))
                WAVE_UP: begin
                    st_d.val = st_q.val + CNT_ONE;
                    st_d.up  = 1'b1;
                end
                WAVE_UP_CRST: begin
                    st_d.val = (st_q.val == top_c) ? '0 : st_q.val + CNT_ONE;
                    st_d.up  = 1'b1;
                end
                default: begin
                    if (st_q.up) begin
                        if (st_q.val >= limit) begin
                            st_d.up  = 1'b0;
                            st_d.val = (limit == '0) ? '0 : st_q.val - CNT_ONE;
                        end else begin
                            st_d.val = st_q.val + CNT_ONE;
                        end
                    end else begin
                        if (st_q.val == '0) begin
                            st_d.up  = 1'b1;
                            st_d.val = (limit == '0) ? '0 : CNT_ONE;
                        end else begin
                            st_d.val = st_q.val - CNT_ONE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= '0;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.val;
    assign at_max = (st_q.val == CNT_MAX);

    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(cnt));

    a_r4_wrap_at_c: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && mode == 2'd2 && cnt == top_c) |=> (cnt == '0));

endmodule

// File: rtl/wt_evt_edge.sv
module wt_evt_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] edge_sel,
    input  logic [1:0] src_sel,
    input  logic       in_b,
    input  logic [2:0] xclk,
    output logic       hit
);
    import wt_pkg::*;

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     cur;
    logic     rise;
    logic     fall;

    always_comb begin
        case (src_sel)
            2'd0:    cur = in_b;
            2'd1:    cur = xclk[0];
            2'd2:    cur = xclk[1];
            default: cur = xclk[2];
        endcase
        rise      = cur & ~st_q.prev;
        fall      = ~cur & st_q.prev;
        st_d.prev = cur;
        case (edge_e'(edge_sel))
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prev <= 1'b0;
        else        st_q      <= st_d;
    end

endmodule

// File: rtl/wt_out_action.sv
module wt_out_action (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_sw,
    input  logic       ev_ext,
    input  logic       ev_cmpc,
    input  logic       ev_own,
    input  logic [1:0] act_sw,
    input  logic [1:0] act_ext,
    input  logic [1:0] act_cmpc,
    input  logic [1:0] act_own,
    output logic       out
);
    import wt_pkg::*;

    typedef struct packed {
        logic lvl;
    } out_st_t;

    out_st_t st_d, st_q;
    act_e    win;

    // lowest rank first, so each later hit overrides it
    always_comb begin
        win = ACT_NONE;
        if (ev_own  && act_own  != 2'd0) win = act_e'(act_own);
        if (ev_cmpc && act_cmpc != 2'd0) win = act_e'(act_cmpc);
        if (ev_ext  && act_ext  != 2'd0) win = act_e'(act_ext);
        if (ev_sw   && act_sw   != 2'd0) win = act_e'(act_sw);
        st_d = st_q;
        case (win)
            ACT_SET: st_d.lvl = 1'b1;
            ACT_CLR: st_d.lvl = 1'b0;
            ACT_TGL: st_d.lvl = ~st_q.lvl;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.lvl <= 1'b0;
        else        st_q     <= st_d;
    end

    assign out = st_q.lvl;

    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (win == ACT_SET) |=> out);

    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (win == ACT_TGL) |=> (out != $past(out)));

    a_r7_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (win == ACT_NONE) |=> $stable(out));

    a_r8_sw_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sw && act_sw == 2'd2) |=> !out);

endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel #(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_start,
    input  logic                     cmd_halt,
    input  logic                     cmd_swtrig,
    input  logic [1:0]               wave_mode,
    input  logic [CNT_W-1:0]         cmp_a,
    input  logic [CNT_W-1:0]         cmp_b,
    input  logic [CNT_W-1:0]         cmp_c,
    input  logic                     stop_at_c,
    input  logic                     halt_at_c,
    input  logic [1:0]               evt_edge,
    input  logic [1:0]               evt_src,
    input  logic                     evt_is_trig,
    input  logic                     in_b,
    input  logic [2:0]               xclk,
    input  logic [1:0]               a_act_cmpa,
    input  logic [1:0]               a_act_cmpc,
    input  logic [1:0]               a_act_evt,
    input  logic [1:0]               a_act_sw,
    input  logic [1:0]               b_act_cmpb,
    input  logic [1:0]               b_act_cmpc,
    input  logic [1:0]               b_act_evt,
    input  logic [1:0]               b_act_sw,
    input  logic                     stat_rd,
    output logic                     out_a,
    output logic                     out_b,
    output logic [CNT_W-1:0]         count,
    output logic [wt_pkg::STAT_W-1:0] status
);
    import wt_pkg::*;

    localparam int N_OUT = 2;

    typedef struct packed {
        logic clk_on;
        logic frozen;
        logic f_ovf;
        logic f_cmpa;
        logic f_cmpb;
        logic f_cmpc;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     run, restart, ext_hit, at_max;
    logic     hit_a, hit_b, hit_c, hit_ovf;

    logic [1:0] act_sw_v  [N_OUT];
    logic [1:0] act_ext_v [N_OUT];
    logic [1:0] act_c_v   [N_OUT];
    logic [1:0] act_own_v [N_OUT];
    logic       own_hit_v [N_OUT];
    logic       out_v     [N_OUT];

    wt_evt_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_sel (evt_edge),
        .src_sel  (evt_src),
        .in_b     (in_b),
        .xclk     (xclk),
        .hit      (ext_hit)
    );

    wt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .mode    (wave_mode),
        .top_c   (cmp_c),
        .cnt     (count),
        .at_max  (at_max)
    );

    always_comb begin
        run     = st_q.clk_on & ~st_q.frozen;
        restart = cmd_swtrig | (ext_hit & evt_is_trig);
        hit_a   = run & (count == cmp_a);
        hit_b   = run & (count == cmp_b);
        hit_c   = run & (count == cmp_c);
        hit_ovf = run & at_max;

        st_d = st_q;
        if (cmd_halt || (hit_c && halt_at_c)) st_d.clk_on = 1'b0;
        else if (cmd_start)                   st_d.clk_on = 1'b1;

        if (restart)                   st_d.frozen = 1'b0;
        else if (hit_c && stop_at_c)   st_d.frozen = 1'b1;

        st_d.f_ovf  = (st_q.f_ovf  & ~stat_rd) | hit_ovf;
        st_d.f_cmpa = (st_q.f_cmpa & ~stat_rd) | hit_a;
        st_d.f_cmpb = (st_q.f_cmpb & ~stat_rd) | hit_b;
        st_d.f_cmpc = (st_q.f_cmpc & ~stat_rd) | hit_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_sw_v[0]  = a_act_sw;
    assign act_ext_v[0] = a_act_evt;
    assign act_c_v[0]   = a_act_cmpc;
    assign act_own_v[0] = a_act_cmpa;
    assign own_hit_v[0] = hit_a;
    assign act_sw_v[1]  = b_act_sw;
    assign act_ext_v[1] = b_act_evt;
    assign act_c_v[1]   = b_act_cmpc;
    assign act_own_v[1] = b_act_cmpb;
    assign own_hit_v[1] = hit_b;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        wt_out_action u_act (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_sw    (cmd_swtrig),
            .ev_ext   (ext_hit),
            .ev_cmpc  (hit_c),
            .ev_own   (own_hit_v[g]),
            .act_sw   (act_sw_v[g]),
            .act_ext  (act_ext_v[g]),
            .act_cmpc (act_c_v[g]),
            .act_own  (act_own_v[g]),
            .out      (out_v[g])
        );
    end

    assign out_a = out_v[0];
    assign out_b = out_v[1];

    always_comb begin
        status            = '0;
        status[ST_OVF]    = st_q.f_ovf;
        status[ST_CMPA]   = st_q.f_cmpa;
        status[ST_CMPB]   = st_q.f_cmpb;
        status[ST_CMPC]   = st_q.f_cmpc;
        status[ST_MIRR_A] = out_a;
        status[ST_MIRR_B] = out_b;
    end

    a_r10_halt_on_c: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && halt_at_c) |=> !st_q.clk_on);

    a_r10_freeze_on_c: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && stop_at_c && !restart) |=> st_q.frozen);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !hit_a && !hit_b && !hit_c && !hit_ovf) |=> (status[4:0] == 5'd0));

    a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ovf |=> status[ST_OVF]);

    a_r2_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_halt && cmd_start) |=> !st_q.clk_on);

endmodule

// File: tb/wave_timer_channel_bench.sv
module wave_timer_channel_bench;
    localparam int W = 8;
    localparam logic [W-1:0] MAXV = '1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_halt = 0, cmd_swtrig = 0;
    logic [1:0] wave_mode = 0;
    logic [W-1:0] cmp_a = 0, cmp_b = 0, cmp_c = 0;
    logic stop_at_c = 0, halt_at_c = 0;
    logic [1:0] evt_edge = 0, evt_src = 0;
    logic evt_is_trig = 0, in_b = 0;
    logic [2:0] xclk = 0;
    logic [1:0] a_act_cmpa = 0, a_act_cmpc = 0, a_act_evt = 0, a_act_sw = 0;
    logic [1:0] b_act_cmpb = 0, b_act_cmpc = 0, b_act_evt = 0, b_act_sw = 0;
    logic stat_rd = 0;
    logic out_a, out_b;
    logic [W-1:0] count;
    logic [18:0] status;

    wave_timer_channel #(.CNT_W(W)) u_wave_timer_channel (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
        .cmd_swtrig(cmd_swtrig), .wave_mode(wave_mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cmp_c(cmp_c), .stop_at_c(stop_at_c), .halt_at_c(halt_at_c), .evt_edge(evt_edge),
        .evt_src(evt_src), .evt_is_trig(evt_is_trig), .in_b(in_b), .xclk(xclk),
        .a_act_cmpa(a_act_cmpa), .a_act_cmpc(a_act_cmpc), .a_act_evt(a_act_evt),
        .a_act_sw(a_act_sw), .b_act_cmpb(b_act_cmpb), .b_act_cmpc(b_act_cmpc),
        .b_act_evt(b_act_evt), .b_act_sw(b_act_sw), .stat_rd(stat_rd),
        .out_a(out_a), .out_b(out_b), .count(count), .status(status)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         oa;
        logic         ob;
        logic [18:0]  st;
        string        tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    errors = 0;
    string phase  = "R1 reset";
    bit    done   = 0;

    // reference state, built from the requirements
    logic [W-1:0] m_cnt = 0;
    logic m_up = 1, m_clk = 0, m_frz = 0, m_oa = 0, m_ob = 0, m_prev = 0;
    logic f_ovf = 0, f_a = 0, f_b = 0, f_c = 0;

    function automatic logic pick(logic cur, logic e_sw, logic e_ext, logic e_c, logic e_own,
                                  logic [1:0] x_sw, logic [1:0] x_ext, logic [1:0] x_c,
                                  logic [1:0] x_own);
        logic [1:0] a;
        a = 2'd0;
        if (e_sw && x_sw != 0)        a = x_sw;       // R8 rank 1
        else if (e_ext && x_ext != 0) a = x_ext;      // R8 rank 2
        else if (e_c && x_c != 0)     a = x_c;        // R8 rank 3
        else if (e_own && x_own != 0) a = x_own;      // R8 rank 4
        case (a)
            2'd1:    return 1'b1;
            2'd2:    return 1'b0;
            2'd3:    return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic model_step();
        logic sel, ext, run, trg, ha, hb, hc, ov, nu;
        logic [W-1:0] lim, nc;
        exp_t e;
        case (evt_src)                                // R9 source codes
            2'd0: sel = in_b;
            2'd1: sel = xclk[0];
            2'd2: sel = xclk[1];
            default: sel = xclk[2];
        endcase
        case (evt_edge)
            2'd1: ext = sel && !m_prev;
            2'd2: ext = !sel && m_prev;
            2'd3: ext = sel != m_prev;
            default: ext = 0;
        endcase
        run = m_clk && !m_frz;
        trg = cmd_swtrig || (ext && evt_is_trig);
        ha = run && m_cnt == cmp_a;
        hb = run && m_cnt == cmp_b;
        hc = run && m_cnt == cmp_c;
        ov = run && m_cnt == MAXV;
        nc = m_cnt; nu = m_up;
        lim = (wave_mode == 2'd3) ? cmp_c : MAXV;
        if (trg) begin nc = 0; nu = 1; end
        else if (run) begin
            if (wave_mode == 2'd0) begin nc = m_cnt + 1; nu = 1; end
            else if (wave_mode == 2'd2) begin nc = (m_cnt == cmp_c) ? 0 : m_cnt + 1; nu = 1; end
            else if (m_up) begin
                if (m_cnt >= lim) begin nu = 0; nc = (lim == 0) ? 0 : m_cnt - 1; end
                else nc = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin nu = 1; nc = (lim == 0) ? 0 : 1; end
                else nc = m_cnt - 1;
            end
        end
        m_oa = pick(m_oa, cmd_swtrig, ext, hc, ha, a_act_sw, a_act_evt, a_act_cmpc, a_act_cmpa);
        m_ob = pick(m_ob, cmd_swtrig, ext, hc, hb, b_act_sw, b_act_evt, b_act_cmpc, b_act_cmpb);
        if (cmd_halt || (hc && halt_at_c)) m_clk = 0;
        else if (cmd_start) m_clk = 1;
        if (trg) m_frz = 0;
        else if (hc && stop_at_c) m_frz = 1;
        if (stat_rd) begin f_ovf = 0; f_a = 0; f_b = 0; f_c = 0; end
        f_ovf = f_ovf | ov; f_a = f_a | ha; f_b = f_b | hb; f_c = f_c | hc;
        m_cnt = nc; m_up = nu; m_prev = sel;
        e.cnt = m_cnt; e.oa = m_oa; e.ob = m_ob; e.tag = phase;
        e.st = '0;
        e.st[0] = f_ovf; e.st[2] = f_a; e.st[3] = f_b; e.st[4] = f_c;
        e.st[17] = m_oa; e.st[18] = m_ob;
        sb.push_back(e);
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // monitor: one expected item per driven cycle, sampled 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " count (R2 R3 R4 R5 R6 R10)"}, 32'(count), 32'(e.cnt));
                check({e.tag, " out_a (R7 R8 R9)"}, 32'(out_a), 32'(e.oa));
                check({e.tag, " out_b (R7 R8 R9)"}, 32'(out_b), 32'(e.ob));
                check({e.tag, " status (R11)"}, 32'(status), 32'(e.st));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset count", 32'(count), 0);
        check("R1 reset out_a", 32'(out_a), 0);
        check("R1 reset out_b", 32'(out_b), 0);
        check("R1 reset status", 32'(status), 0);
        rst_n = 1;

        phase = "R1 R2 clock off"; ticks(5);
        phase = "R2 start";
        cmd_start = 1; tick(); cmd_start = 0; ticks(10);
        phase = "R2 halt beats start";
        cmd_start = 1; cmd_halt = 1; tick(); cmd_start = 0; cmd_halt = 0; ticks(5);
        cmd_start = 1; tick(); cmd_start = 0;

        phase = "R3 up wrap";
        wave_mode = 0; cmp_a = 10; cmp_b = 200; cmp_c = 100;
        a_act_cmpa = 1; a_act_cmpc = 2; b_act_cmpb = 3; b_act_cmpc = 1;
        for (int i = 0; i < 12; i++) begin
            ticks(49); stat_rd = 1; tick(); stat_rd = 0;
        end

        phase = "R4 reset at C";
        cmd_swtrig = 1; tick(); cmd_swtrig = 0;
        wave_mode = 2; cmp_c = 40; cmp_a = 5; cmp_b = 20; ticks(150);

        phase = "R5 up-down full";
        wave_mode = 1; ticks(600);
        phase = "R5 up-down to C";
        wave_mode = 3; cmp_c = 30; ticks(150);
        cmp_c = 0; ticks(20); cmp_c = 30; ticks(80);

        phase = "R6 software trigger";
        a_act_sw = 3; b_act_sw = 2;
        for (int g = 1; g < 8; g++) begin
            cmd_swtrig = 1; tick(); cmd_swtrig = 0; ticks(g * 5);
        end

        phase = "R9 external events";
        a_act_evt = 3; b_act_evt = 1; wave_mode = 0;
        for (int s = 0; s < 4; s++) begin
            for (int ed = 0; ed < 4; ed++) begin
                evt_src = 2'(s); evt_edge = 2'(ed); evt_is_trig = ed[0];
                for (int k = 0; k < 6; k++) begin
                    in_b = ~in_b; xclk = ~xclk; ticks(3);
                end
            end
        end
        evt_edge = 0; evt_is_trig = 0;

        phase = "R8 priority";
        wave_mode = 2; cmp_a = 12; cmp_c = 12; a_act_cmpa = 1; a_act_cmpc = 2;
        b_act_cmpb = 3; cmp_b = 12; b_act_cmpc = 0;
        for (int i = 0; i < 10; i++) begin
            ticks(12); cmd_swtrig = 1; tick(); cmd_swtrig = 0;
        end
        evt_edge = 3; a_act_sw = 0;
        for (int i = 0; i < 10; i++) begin
            ticks(11); in_b = ~in_b; evt_src = 0; tick();
        end
        evt_edge = 0; a_act_sw = 3;

        phase = "R10 freeze on C";
        wave_mode = 0; cmp_c = 50; stop_at_c = 1; ticks(300);
        cmd_swtrig = 1; tick(); cmd_swtrig = 0; ticks(100);
        stop_at_c = 0;
        phase = "R10 halt on C";
        halt_at_c = 1; ticks(300);
        halt_at_c = 0; cmd_start = 1; tick(); cmd_start = 0; ticks(60);

        phase = "R11 status reads";
        cmp_a = 3; cmp_b = 4; cmp_c = 5; wave_mode = 2;
        for (int i = 0; i < 40; i++) begin
            stat_rd = i[0]; tick();
        end
        stat_rd = 0;

        phase = "R7 R8 R9 R10 R11 mixed";
        for (int i = 0; i < 2500; i++) begin
            logic [31:0] r;
            r = $urandom;
            cmd_start = (r[3:0] == 0); cmd_halt = (r[7:3] == 0); cmd_swtrig = (r[11:6] == 0);
            stat_rd = r[12]; in_b = r[13]; xclk = r[16:14];
            if (r[22:17] == 0) begin
                r = $urandom;
                wave_mode = r[1:0]; evt_edge = r[3:2]; evt_src = r[5:4]; evt_is_trig = r[6];
                stop_at_c = r[7] & r[8]; halt_at_c = r[9] & r[10];
                a_act_cmpa = r[12:11]; a_act_cmpc = r[14:13]; a_act_evt = r[16:15];
                a_act_sw = r[18:17]; b_act_cmpb = r[20:19]; b_act_cmpc = r[22:21];
                b_act_evt = r[24:23]; b_act_sw = r[26:25];
                r = $urandom;
                cmp_a = r[7:0]; cmp_b = r[15:8]; cmp_c = r[23:16];
            end
            tick();
        end
        cmd_start = 0; cmd_halt = 0; cmd_swtrig = 0; stat_rd = 0;
        ticks(2);
        @(posedge clk); #3;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule